// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block recovers start/stop framed words from a single serial input line. Every bit is sampled at its midpoint, using a bit clock derived from a programmable divisor. Each finished word enters a small first-in first-out receive buffer behind the shift register, and the buffer holds two words by default. The head word's data, its optional ninth bit and its framing-error status appear on the outputs at all times. A one-cycle read strobe on `dataRd` discards the head and exposes the next word. Software therefore samples the ninth bit and the error status first, and the data with the strobe last.

Reception needs three conditions: the port enable is set, the synchronous-mode select is clear, and the receive enable is set. A word that completes while the buffer is full sets a sticky overrun flag, and that word is dropped. While the flag is set, no further word enters the buffer. Words already held stay readable. The only way to clear the flag is to drop the receive enable low for at least one cycle. A ready flag shows that the buffer is not empty. An interrupt request follows that flag when the interrupt enable is set.

Top module: `uart_rx_buf`

## Requirements
- R1: No word enters the buffer unless `portEn`=1, `syncMode`=0 and `rxEn`=1 all hold during the whole frame. Frames sent otherwise leave `rxReady` low.
- R2: A frame is one low start bit, then DATA_W data bits with the least significant bit first, then a high stop bit. A start bit that reads high at its midpoint is discarded.
- R3: With `nineBit`=1 an extra bit follows the last data bit, and it is reported on `rxBit9` with its word. With `nineBit`=0 `rxBit9` reads 0.
- R4: If the stop bit is sampled low, the word is still stored, and its `frameErr` reads 1. Otherwise it reads 0.
- R5: Words leave the buffer in arrival order. The outputs `rxData`, `rxBit9` and `frameErr` show the head word, and a `dataRd` pulse advances to the next word.
- R6: `rxReady` is 1 exactly while the buffer holds a word. While `rxReady` is 0, the outputs `rxData`, `rxBit9` and `frameErr` read 0. A `dataRd` pulse on an empty buffer changes nothing.
- R7: `irq` is 1 only when `rxReady` and `intEn` are both 1.
- R8: A word that completes while DEPTH words are held sets `overrun` and is dropped. While `overrun` is 1, no completed word enters the buffer, and held words stay readable in order.
- R9: `overrun` stays set while `rxEn` is 1. It clears in the cycle after `rxEn` is sampled 0.
- R10: After reset, `rxReady`, `overrun`, `irq`, `frameErr`, `rxBit9` and `rxData` are all 0.
- R11: One bit lasts (baudDiv+1)×64 clocks with `highSpeed`=0 and (baudDiv+1)×16 clocks with `highSpeed`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input line, idles high |
| baudDiv | input | DIV_W | Bit-rate divisor |
| highSpeed | input | 1 | Selects 16 instead of 64 divisor ticks per bit |
| portEn | input | 1 | Serial port enable |
| syncMode | input | 1 | Synchronous mode select; reception is blocked when 1 |
| rxEn | input | 1 | Continuous receive enable; a low level clears overrun |
| nineBit | input | 1 | Expect a ninth data bit in each frame |
| intEn | input | 1 | Receive interrupt enable |
| dataRd | input | 1 | Read strobe; discards the head word |
| rxData | output | DATA_W | Head word data |
| rxBit9 | output | 1 | Head word ninth bit |
| frameErr | output | 1 | Head word framing error |
| rxReady | output | 1 | Buffer is not empty |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench keeps the default parameters: an 8-bit divisor, a two-word buffer, 8 data bits and oversampling ratios of 64 and 16. With these values, filling the buffer and overrunning it takes only three frames. The bench drives divisors 0 and 2 at run time in high-speed mode and divisor 0 in normal mode, so each bit lasts 16, 48 or 64 clocks. Those short bit periods let it cover both rate paths, 9-bit frames, bad stop bits and the whole overrun set-and-clear sequence within the cycle budget.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic cntClr;     // restart bit timing, clear ninth-bit capture
    logic shiftIn;    // shift the sampled line into the data register
    logic bit9In;     // capture the sampled line as the ninth bit
    logic frameDone;  // sample stop bit and offer the word to the buffer
  } ctrlStrobe_t;

  // Timing and line status from datapath to control
  typedef struct packed {
    logic lineS;      // synchronized serial line
    logic halfHit;    // middle of the start bit reached
    logic fullHit;    // middle of a data or stop bit reached
  } dpStatus_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_BIT9,
    RX_STOP
  } rxState_t;

endpackage

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 2,
  parameter int LO_OVS  = 64,
  parameter int HI_OVS  = 16,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              highSpeed,
  input  logic              rxEn,
  input  logic              dataRd,
  input  ctrlStrobe_t       strb,
  output dpStatus_t         stat,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              frameErr,
  output logic              rxReady,
  output logic              overrun
);

  localparam int SUB_W = $clog2(LO_OVS);
  localparam int ENT_W = DATA_W + 2;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // ---------------- line synchronizer ----------------
  logic [SYNC_N-1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_N-2:0], rxLine};
  end
  logic lineS;
  assign lineS = syncQ[SYNC_N-1];

  // ---------------- bit timing ----------------
  logic [DIV_W-1:0] preCnt;
  logic [SUB_W-1:0] subCnt;
  logic             tick;
  logic [SUB_W-1:0] subMax;
  logic [SUB_W-1:0] subHalf;

  assign tick    = (preCnt == baudDiv);
  assign subMax  = highSpeed ? SUB_W'(HI_OVS - 1)     : SUB_W'(LO_OVS - 1);
  assign subHalf = highSpeed ? SUB_W'(HI_OVS / 2 - 1) : SUB_W'(LO_OVS / 2 - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      subCnt <= '0;
    end else if (strb.cntClr) begin
      preCnt <= '0;
      subCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      subCnt <= (subCnt == subMax) ? '0 : subCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign stat.lineS   = lineS;
  assign stat.halfHit = tick && (subCnt == subHalf);
  assign stat.fullHit = tick && (subCnt == subMax);

  // ---------------- shift register ----------------
  logic [DATA_W-1:0] shReg;
  logic              b9q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      b9q   <= 1'b0;
    end else begin
      if (strb.shiftIn) shReg <= {lineS, shReg[DATA_W-1:1]};
      if (strb.cntClr)      b9q <= 1'b0;
      else if (strb.bit9In) b9q <= lineS;
    end
  end

  logic [ENT_W-1:0] newEnt;
  assign newEnt = {b9q, ~lineS, shReg};

  // ---------------- receive buffer ----------------
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             isFull, isEmpty, doPush, doPop, ovrQ;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);
  assign doPush  = strb.frameDone && !isFull && !ovrQ;
  assign doPop   = dataRd && !isEmpty;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    mem[gi] <= '0;
      else if (doPush && wrPtr == PTR_W'(gi))        mem[gi] <= newEnt;
    end
  end

  // ---------------- overrun ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            ovrQ <= 1'b0;
    else if (!rxEn)                       ovrQ <= 1'b0;
    else if (strb.frameDone && isFull)    ovrQ <= 1'b1;
  end

  // ---------------- head presentation ----------------
  logic [ENT_W-1:0] headEnt;
  assign headEnt  = isEmpty ? '0 : mem[rdPtr];
  assign rxData   = headEnt[DATA_W-1:0];
  assign frameErr = headEnt[DATA_W];
  assign rxBit9   = headEnt[DATA_W+1];
  assign rxReady  = !isEmpty;
  assign overrun  = ovrQ;

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxOn,
  input  logic        nineBit,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rxState_t         state, stateNx;
  logic [BIT_W-1:0] bitCnt, bitCntNx;

  always_comb begin
    stateNx  = state;
    bitCntNx = bitCnt;
    strb     = '0;
    if (!rxOn) begin
      stateNx = RX_IDLE;
    end else begin
      case (state)
        RX_IDLE: begin
          if (!stat.lineS) begin
            strb.cntClr = 1'b1;
            stateNx     = RX_START;
          end
        end
        RX_START: begin
          if (stat.halfHit) begin
            if (stat.lineS) begin
              stateNx = RX_IDLE;
            end else begin
              strb.cntClr = 1'b1;
              bitCntNx    = '0;
              stateNx     = RX_DATA;
            end
          end
        end
        RX_DATA: begin
          if (stat.fullHit) begin
            strb.shiftIn = 1'b1;
            if (bitCnt == LAST_BIT) stateNx = nineBit ? RX_BIT9 : RX_STOP;
            else                    bitCntNx = bitCnt + 1'b1;
          end
        end
        RX_BIT9: begin
          if (stat.fullHit) begin
            strb.bit9In = 1'b1;
            stateNx     = RX_STOP;
          end
        end
        RX_STOP: begin
          if (stat.fullHit) begin
            strb.frameDone = 1'b1;
            stateNx        = RX_IDLE;
          end
        end
        default: stateNx = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNx;
      bitCnt <= bitCntNx;
    end
  end

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int LO_OVS = 64,
  parameter int HI_OVS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              highSpeed,
  input  logic              portEn,
  input  logic              syncMode,
  input  logic              rxEn,
  input  logic              nineBit,
  input  logic              intEn,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              frameErr,
  output logic              rxReady,
  output logic              overrun,
  output logic              irq
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;
  logic        rxOn;

  assign rxOn = portEn && !syncMode && rxEn;

  uart_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxOn    (rxOn),
    .nineBit (nineBit),
    .stat    (stat),
    .strb    (strb)
  );

  uart_rx_dp #(
    .DIV_W  (DIV_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .LO_OVS (LO_OVS),
    .HI_OVS (HI_OVS),
    .SYNC_N (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .baudDiv   (baudDiv),
    .highSpeed (highSpeed),
    .rxEn      (rxEn),
    .dataRd    (dataRd),
    .strb      (strb),
    .stat      (stat),
    .rxData    (rxData),
    .rxBit9    (rxBit9),
    .frameErr  (frameErr),
    .rxReady   (rxReady),
    .overrun   (overrun)
  );

  assign irq = rxReady && intEn;

endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              portEn,
  input logic              rxEn,
  input logic              intEn,
  input logic              rxReady,
  input logic              overrun,
  input logic              irq,
  input logic              frameErr,
  input logic              rxBit9,
  input logic [DATA_W-1:0] rxData
);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rxReady && intEn));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && rxEn) |=> overrun);

  assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !overrun);

  assert_overrun_when_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> rxReady);

  assert_port_off_no_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!portEn && !rxReady) |=> !rxReady);

  assert_empty_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rxReady |-> (rxData == '0 && !rxBit9 && !frameErr));

endmodule

bind uart_rx_buf uart_rx_buf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .portEn   (portEn),
  .rxEn     (rxEn),
  .intEn    (intEn),
  .rxReady  (rxReady),
  .overrun  (overrun),
  .irq      (irq),
  .frameErr (frameErr),
  .rxBit9   (rxBit9),
  .rxData   (rxData)
);

// File: tb/tb_uart_rx_buf.sv
module tb_uart_rx_buf;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic [7:0] baudDiv = '0;
  logic       highSpeed = 1'b1;
  logic       portEn = 1'b0, syncMode = 1'b0, rxEn = 1'b0;
  logic       nineBit = 1'b0, intEn = 1'b0, dataRd = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9, frameErr, rxReady, overrun, irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit autoDrain = 1'b0;
  logic [9:0] expQ[$];

  always #2 clk = ~clk;

  uart_rx_buf dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudDiv(baudDiv),
    .highSpeed(highSpeed), .portEn(portEn), .syncMode(syncMode),
    .rxEn(rxEn), .nineBit(nineBit), .intEn(intEn), .dataRd(dataRd),
    .rxData(rxData), .rxBit9(rxBit9), .frameErr(frameErr),
    .rxReady(rxReady), .overrun(overrun), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bitClk();
    return (int'(baudDiv) + 1) * (highSpeed ? 16 : 64);
  endfunction

  task automatic holdLine(input logic v, input int n);
    rxLine = v;
    repeat (n) @(negedge clk);
  endtask

  // Driver: sends one frame, pushes the expected word when it should be stored
  task automatic sendFrame(input logic [7:0] d, input logic b9,
                           input bit stopOk, input bit expectIn);
    int bc;
    bc = bitClk();
    if (expectIn) expQ.push_back({b9 & nineBit, ~stopOk, d});
    holdLine(1'b0, bc);
    for (int i = 0; i < 8; i++) holdLine(d[i], bc);
    if (nineBit) holdLine(b9, bc);
    if (stopOk) holdLine(1'b1, bc);
    else begin
      holdLine(1'b0, (bc * 3) / 4);
      holdLine(1'b1, bc - (bc * 3) / 4);
    end
    holdLine(1'b1, bc * 2);
  endtask

  // Monitor: while draining automatically, compare the head word with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (autoDrain) begin
        if (rxReady && !dataRd) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R5", "unexpected word", {rxBit9, frameErr, rxData}, 0);
          end else begin
            logic [9:0] e;
            e = expQ.pop_front();
            chk({rxBit9, frameErr, rxData} == e, "R2/R3/R4/R5", "head word",
                {rxBit9, frameErr, rxData}, e);
          end
          dataRd = 1'b1;
        end else begin
          dataRd = 1'b0;
        end
      end
    end
  end

  task automatic manualRead(input string req);
    logic [9:0] e;
    @(negedge clk);
    if (expQ.size() == 0) begin
      chk(1'b0, req, "queue empty on read", 0, 0);
    end else begin
      e = expQ.pop_front();
      chk({rxBit9, frameErr, rxData} == e, req, "manual read",
          {rxBit9, frameErr, rxData}, e);
    end
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
  endtask

  task automatic waitDrain(input string req);
    for (int i = 0; i < 400 && expQ.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, req, "words left undelivered", expQ.size(), 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    chk({rxReady, overrun, irq, frameErr, rxBit9} == 5'b0 && rxData == 8'h00,
        "R10", "reset outputs", {rxReady, overrun, irq, frameErr, rxBit9, rxData}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rxReady && !overrun, "R10", "after reset release", {rxReady, overrun}, 0);

    // R2/R5: basic words, high speed, divisor 0
    portEn = 1'b1; rxEn = 1'b1; autoDrain = 1'b1;
    sendFrame(8'hA5, 1'b0, 1'b1, 1'b1);
    sendFrame(8'h3C, 1'b0, 1'b1, 1'b1);
    sendFrame(8'h00, 1'b0, 1'b1, 1'b1);
    sendFrame(8'hFF, 1'b0, 1'b1, 1'b1);
    waitDrain("R2");

    // R11: divisor 2 at high speed, then divisor 0 at normal speed
    baudDiv = 8'd2;
    sendFrame(8'h5A, 1'b0, 1'b1, 1'b1);
    waitDrain("R11");
    baudDiv = 8'd0; highSpeed = 1'b0;
    sendFrame(8'h81, 1'b0, 1'b1, 1'b1);
    waitDrain("R11");
    highSpeed = 1'b1;

    // R2: short low glitch is a false start
    holdLine(1'b0, 3);
    holdLine(1'b1, bitClk() * 12);
    chk(!rxReady, "R2", "false start stored", rxReady, 0);

    // R3: nine-bit frames
    nineBit = 1'b1;
    sendFrame(8'h12, 1'b1, 1'b1, 1'b1);
    sendFrame(8'h34, 1'b0, 1'b1, 1'b1);
    waitDrain("R3");
    nineBit = 1'b0;

    // R4: bad stop bit still stored with error
    sendFrame(8'h77, 1'b0, 1'b0, 1'b1);
    sendFrame(8'h66, 1'b0, 1'b1, 1'b1);
    waitDrain("R4");

    autoDrain = 1'b0;
    dataRd = 1'b0;
    repeat (4) @(negedge clk);

    // R7/R6: interrupt and manual reads
    intEn = 1'b1;
    sendFrame(8'hC3, 1'b0, 1'b1, 1'b1);
    chk(rxReady, "R6", "ready with one word", rxReady, 1);
    chk(irq, "R7", "irq with intEn", irq, 1);
    intEn = 1'b0;
    @(negedge clk);
    chk(!irq, "R7", "irq without intEn", irq, 0);
    intEn = 1'b1;
    manualRead("R5");
    chk(!rxReady && !irq, "R6", "ready after last read", {rxReady, irq}, 0);
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
    @(negedge clk);
    chk(!rxReady && rxData == 8'h00 && !overrun, "R6", "read of empty buffer",
        {rxReady, overrun, rxData}, 0);
    intEn = 1'b0;

    // R8: overrun with a two-deep buffer
    sendFrame(8'h11, 1'b0, 1'b1, 1'b1);
    sendFrame(8'h22, 1'b0, 1'b1, 1'b1);
    chk(!overrun, "R8", "two words no overrun", overrun, 0);
    sendFrame(8'h33, 1'b0, 1'b1, 1'b0);
    chk(overrun, "R8", "third word overrun", overrun, 1);
    sendFrame(8'h44, 1'b0, 1'b1, 1'b0);
    manualRead("R8");
    manualRead("R8");
    chk(!rxReady, "R8", "only two words held", rxReady, 0);
    sendFrame(8'h55, 1'b0, 1'b1, 1'b0);
    chk(!rxReady, "R8", "word blocked while overrun", rxReady, 0);
    chk(overrun, "R9", "overrun sticky", overrun, 1);

    // R9: clear by toggling receive enable
    rxEn = 1'b0;
    @(negedge clk);
    chk(!overrun, "R9", "overrun cleared", overrun, 0);
    rxEn = 1'b1;
    sendFrame(8'h9D, 1'b0, 1'b1, 1'b1);
    chk(rxReady && !overrun, "R9", "receive resumes", {rxReady, overrun}, 2);
    manualRead("R9");

    // R1: reception gated by enables
    portEn = 1'b0;
    sendFrame(8'hE1, 1'b0, 1'b1, 1'b0);
    chk(!rxReady, "R1", "port disabled", rxReady, 0);
    portEn = 1'b1; syncMode = 1'b1;
    sendFrame(8'hE2, 1'b0, 1'b1, 1'b0);
    chk(!rxReady, "R1", "sync mode", rxReady, 0);
    syncMode = 1'b0; rxEn = 1'b0;
    sendFrame(8'hE3, 1'b0, 1'b1, 1'b0);
    chk(!rxReady, "R1", "receive disabled", rxReady, 0);
    rxEn = 1'b1;
    sendFrame(8'hE4, 1'b0, 1'b1, 1'b1);
    manualRead("R1");
    chk(expQ.size() == 0, "R5", "queue empty at end", expQ.size(), 0);

    finish();
  end

endmodule